// File: doc/BRIEF.md
# Bit-Parallel Ternary Fault Evaluator

This block evaluates one logic gate for many copies of a circuit in the same clock cycle. Every bit position (lane) of a word stands for one circuit copy. The highest lane is always the fault-free circuit, and each lower lane is a circuit with one injected fault. A value in a lane is three-valued (0, 1 or unknown). It is carried on two rails: bit `l` of the high rail and bit `l` of the low rail together make the value of lane `l`.

Up to `NIN` operand words reach the gate. Before evaluation, each operand passes through its own fault-injection stage. That stage can force chosen faulted lanes to a stuck-at-0 or stuck-at-1 value. The gate then applies AND, OR, NOT or buffer, lane by lane, with unknown-aware rules. The result is registered. When the caller marks the gate as driving a primary output, the block also registers a detection vector. That vector flags each faulted lane whose definite value differs from a definite fault-free value.

The output side has two states. In `ST_IDLE`, no result was taken on the last edge. In `ST_LOAD`, a result was taken on the last edge. The transition `ST_IDLE -> ST_LOAD` and the hold `ST_LOAD -> ST_LOAD` happen on any edge with `in_valid` high. The transition `ST_LOAD -> ST_IDLE` and the hold `ST_IDLE -> ST_IDLE` happen on any edge with `in_valid` low. Reset enters `ST_IDLE`.

Top module: `tfe_fault_eval`

## Requirements
- R1: Lane encoding on the rails (high, low) is: (0,1) means 0, (1,0) means 1 and (1,1) means unknown. An input pair (0,0) is treated as unknown. A result lane never shows (0,0).
- R2: Opcode 2'b00 (AND) gives a lane result of 0 if any enabled operand is 0 in that lane. It gives 1 if all enabled operands are 1. In every other case it gives unknown.
- R3: Opcode 2'b01 (OR) gives 1 if any enabled operand is 1. It gives 0 if all enabled operands are 0. In every other case it gives unknown.
- R4: Opcode 2'b10 (NOT) swaps the rails of operand 0, so unknown stays unknown. Opcode 2'b11 (buffer) passes operand 0 through. Both opcodes ignore the enable bits.
- R5: An operand whose bit in `op_en` is 0 has no effect on AND or OR. With no operand enabled, AND gives 1 and OR gives 0.
- R6: A 0 in bit `i*LANES+l` of `clr_n` forces lane `l` of operand `i` to 0. No other lane of that operand changes.
- R7: A 1 in bit `i*LANES+l` of `set_m` forces lane `l` of operand `i` to 1. If the same lane also has its `clr_n` bit at 0, the lane is forced to 0 instead.
- R8: Mask bits that address the top (fault-free) lane have no effect.
- R9: The result, `out_valid` and `det` appear on the clock edge that samples `in_valid` high. While `in_valid` is low, the result holds its value and `out_valid` falls after the next edge.
- R10: With `is_po` high, bit `l` of `det` is 1 exactly when result lane `l` and the top lane are both definite and they differ.
- R11: When the top result lane is unknown, `det` is all zero.
- R12: `det` is all zero after an edge that samples `is_po` low or `in_valid` low.
- R13: During reset, `out_valid` is 0, `det` is 0 and every result lane is unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 2 | Gate opcode: 00 AND, 01 OR, 10 NOT, 11 buffer |
| op_en | input | NIN | Per-operand enable for AND and OR |
| is_po | input | 1 | The gate drives a primary output, so detection is enabled |
| opnd_r1 | input | NIN*LANES | High rails of all operands; operand i at bits i*LANES +: LANES |
| opnd_r0 | input | NIN*LANES | Low rails of all operands, same layout |
| set_m | input | NIN*LANES | Stuck-at-1 masks, active high, same layout |
| clr_n | input | NIN*LANES | Stuck-at-0 masks, active low, same layout |
| out_valid | output | 1 | A result was registered on the last edge |
| res_r1 | output | LANES | Result high rail |
| res_r0 | output | LANES | Result low rail |
| det | output | LANES-1 | Detection flags for the faulted lanes |

## Verification
The bench builds the block with `LANES=3` and `NIN=2`, which gives one fault-free lane and two faulted lanes. With these values, the rails of both operands fit in 12 bits. For each opcode, all 4096 operand-rail combinations are applied with shifting enables and `is_po`. This covers every ternary pairing, including the illegal (0,0) code. A second sweep covers all 4096 combinations of set and clear masks. That sweep reaches both-masks-set conflicts, masks on the fault-free lane, and detections in which the fault-free lane is unknown.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_NOT = 2'b10,
        OP_BUF = 2'b11
    } gate_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } out_st_e;

endpackage

// File: rtl/tfe_inject.sv
module tfe_inject #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] in_r1,
    input  logic [LANES-1:0] in_r0,
    input  logic [LANES-1:0] set_m,
    input  logic [LANES-1:0] clr_n,
    output logic [LANES-1:0] out_r1,
    output logic [LANES-1:0] out_r0
);
    // lanes that may carry a fault: all but the top one
    localparam logic [LANES-1:0] FLT_LANES = {1'b0, {(LANES-1){1'b1}}};

    logic [LANES-1:0] force1, force0, f_r1, f_r0, bad;

    always_comb begin
        force0 = ~clr_n & FLT_LANES;
        force1 = set_m & FLT_LANES;
        // clear has priority over set
        f_r1   = (in_r1 | force1) & ~force0;
        f_r0   = (in_r0 & ~force1) | force0;
        // illegal (0,0) becomes unknown
        bad    = ~f_r1 & ~f_r0;
        out_r1 = f_r1 | bad;
        out_r0 = f_r0 | bad;
    end

endmodule

// File: rtl/tfe_gate.sv
module tfe_gate
    import tfe_pkg::*;
#(
    parameter int LANES = 8,
    parameter int NIN   = 4
) (
    input  logic [NIN*LANES-1:0] q_r1,
    input  logic [NIN*LANES-1:0] q_r0,
    input  logic [NIN-1:0]       en,
    input  gate_op_e             op,
    output logic [LANES-1:0]     y_r1,
    output logic [LANES-1:0]     y_r0
);
    logic [LANES-1:0] any0, all1, any1, all0;

    always_comb begin
        any0 = '0;
        any1 = '0;
        all0 = '1;
        all1 = '1;
        for (int i = 0; i < NIN; i++) begin
            if (en[i]) begin
                any0 = any0 | (q_r0[i*LANES +: LANES] & ~q_r1[i*LANES +: LANES]);
                any1 = any1 | (q_r1[i*LANES +: LANES] & ~q_r0[i*LANES +: LANES]);
                all0 = all0 & (q_r0[i*LANES +: LANES] & ~q_r1[i*LANES +: LANES]);
                all1 = all1 & (q_r1[i*LANES +: LANES] & ~q_r0[i*LANES +: LANES]);
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_AND: begin
                y_r1 = ~any0;
                y_r0 = ~all1;
            end
            OP_OR: begin
                y_r1 = ~all0;
                y_r0 = ~any1;
            end
            OP_NOT: begin
                y_r1 = q_r0[LANES-1:0];
                y_r0 = q_r1[LANES-1:0];
            end
            OP_BUF: begin
                y_r1 = q_r1[LANES-1:0];
                y_r0 = q_r0[LANES-1:0];
            end
            default: begin
                y_r1 = '1;
                y_r0 = '1;
            end
        endcase
    end

endmodule

// File: rtl/tfe_detect.sv
module tfe_detect #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] y_r1,
    input  logic [LANES-1:0] y_r0,
    output logic [LANES-2:0] hit
);
    localparam int TOP = LANES - 1;

    logic good_def;

    assign good_def = y_r1[TOP] ^ y_r0[TOP];

    for (genvar l = 0; l < TOP; l++) begin : g_lane
        assign hit[l] = good_def & (y_r1[l] ^ y_r0[l]) & (y_r1[l] ^ y_r1[TOP]);
    end

endmodule

// File: rtl/tfe_fault_eval.sv
module tfe_fault_eval
    import tfe_pkg::*;
#(
    parameter int LANES = 8,
    parameter int NIN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           op,
    input  logic [NIN-1:0]       op_en,
    input  logic                 is_po,
    input  logic [NIN*LANES-1:0] opnd_r1,
    input  logic [NIN*LANES-1:0] opnd_r0,
    input  logic [NIN*LANES-1:0] set_m,
    input  logic [NIN*LANES-1:0] clr_n,
    output logic                 out_valid,
    output logic [LANES-1:0]     res_r1,
    output logic [LANES-1:0]     res_r0,
    output logic [LANES-2:0]     det
);
    localparam int WBUS = NIN * LANES;

    logic [WBUS-1:0]  inj_r1, inj_r0;
    logic [LANES-1:0] y_r1, y_r0;
    logic [LANES-2:0] hit;
    out_st_e          st_q, st_d;

    for (genvar i = 0; i < NIN; i++) begin : g_inj
        tfe_inject #(.LANES(LANES)) u_inj (
            .in_r1  (opnd_r1[i*LANES +: LANES]),
            .in_r0  (opnd_r0[i*LANES +: LANES]),
            .set_m  (set_m[i*LANES +: LANES]),
            .clr_n  (clr_n[i*LANES +: LANES]),
            .out_r1 (inj_r1[i*LANES +: LANES]),
            .out_r0 (inj_r0[i*LANES +: LANES])
        );
    end

    tfe_gate #(.LANES(LANES), .NIN(NIN)) u_gate (
        .q_r1 (inj_r1),
        .q_r0 (inj_r0),
        .en   (op_en),
        .op   (gate_op_e'(op)),
        .y_r1 (y_r1),
        .y_r0 (y_r0)
    );

    tfe_detect #(.LANES(LANES)) u_det (
        .y_r1 (y_r1),
        .y_r0 (y_r0),
        .hit  (hit)
    );

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_LOAD : ST_IDLE;
            ST_LOAD: st_d = in_valid ? ST_LOAD : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_r1 <= '1;
            res_r0 <= '1;
            det    <= '0;
        end else if (in_valid) begin
            res_r1 <= y_r1;
            res_r0 <= y_r0;
            det    <= is_po ? hit : '0;
        end else begin
            det    <= '0;
        end
    end

    assign out_valid = (st_q == ST_LOAD);

endmodule

// File: rtl/tfe_chk.sv
module tfe_chk #(
    parameter int LANES = 8,
    parameter int NIN   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             is_po,
    input logic             out_valid,
    input logic [LANES-1:0] res_r1,
    input logic [LANES-1:0] res_r0,
    input logic [LANES-2:0] det
);
    localparam int TOP = LANES - 1;

    p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_r1) && $stable(res_r0)));

    p_nodet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !is_po) |=> (det == '0));

    p_goodx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_r1[TOP] && res_r0[TOP]) |-> (det == '0));

    p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((~res_r1 & ~res_r0) == '0));

    p_rst_r13: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && det == '0));

endmodule

bind tfe_fault_eval tfe_chk #(.LANES(LANES), .NIN(NIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .is_po     (is_po),
    .out_valid (out_valid),
    .res_r1    (res_r1),
    .res_r0    (res_r0),
    .det       (det)
);

// File: tb/sim_tfe_fault_eval.sv
module sim_tfe_fault_eval;
    localparam int L = 3;
    localparam int N = 2;
    localparam int W = L * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op = '0;
    logic [N-1:0] op_en = '0;
    logic         is_po = 1'b0;
    logic [W-1:0] opnd_r1 = '0, opnd_r0 = '0, set_m = '0, clr_n = '1;
    logic         out_valid;
    logic [L-1:0] res_r1, res_r0;
    logic [L-2:0] det;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    tfe_fault_eval #(.LANES(L), .NIN(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .op_en(op_en),
        .is_po(is_po), .opnd_r1(opnd_r1), .opnd_r0(opnd_r0), .set_m(set_m),
        .clr_n(clr_n), .out_valid(out_valid), .res_r1(res_r1), .res_r0(res_r0),
        .det(det)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int dec(input logic h, input logic lo);
        if (h && !lo) return 1;
        if (!h && lo) return 0;
        return 2;
    endfunction

    task automatic apply(input logic [1:0] o, input logic [W-1:0] a1, input logic [W-1:0] a0,
                         input logic [W-1:0] sm, input logic [W-1:0] cn,
                         input logic [N-1:0] en, input logic po, input string tag);
        int v [N];
        int rl [L];
        logic [L-1:0] x1, x0;
        logic [L-2:0] xd;
        bit any0, all1, any1, all0;
        for (int l = 0; l < L; l++) begin
            for (int i = 0; i < N; i++) begin
                v[i] = dec(a1[i*L+l], a0[i*L+l]);
                if (l < L-1) begin
                    if (!cn[i*L+l]) v[i] = 0;
                    else if (sm[i*L+l]) v[i] = 1;
                end
            end
            any0 = 0; all1 = 1; any1 = 0; all0 = 1;
            for (int i = 0; i < N; i++) begin
                if (en[i]) begin
                    if (v[i] == 0) any0 = 1;
                    if (v[i] != 1) all1 = 0;
                    if (v[i] == 1) any1 = 1;
                    if (v[i] != 0) all0 = 0;
                end
            end
            case (o)
                2'b00: rl[l] = any0 ? 0 : (all1 ? 1 : 2);
                2'b01: rl[l] = any1 ? 1 : (all0 ? 0 : 2);
                2'b10: rl[l] = (v[0] == 2) ? 2 : 1 - v[0];
                default: rl[l] = v[0];
            endcase
            x1[l] = (rl[l] != 0);
            x0[l] = (rl[l] != 1);
        end
        for (int l = 0; l < L-1; l++)
            xd[l] = po && rl[L-1] != 2 && rl[l] != 2 && rl[l] != rl[L-1];
        op = o; opnd_r1 = a1; opnd_r0 = a0; set_m = sm; clr_n = cn;
        op_en = en; is_po = po; in_valid = 1'b1;
        @(negedge clk);
        check(res_r1 == x1 && res_r0 == x0, tag, {res_r1, res_r0}, {x1, x0});
        check(det == xd, (rl[L-1] == 2) ? "R11" : (po ? "R10" : "R12"), det, xd);
        check(out_valid == 1'b1, "R9", out_valid, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [L-1:0] h1, h0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(out_valid == 1'b0, "R13", out_valid, 0);
        check(det == '0, "R13", det, 0);
        check(res_r1 == '1 && res_r0 == '1, "R13", {res_r1, res_r0}, {L{2'b11}});
        rst_n = 1'b1;
        @(negedge clk);

        // operand sweep: R1 R2 R3 R4 R5
        for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4096; k++) begin
                logic [11:0] b;
                b = 12'(k);
                apply(2'(o), b[5:0], b[11:6], '0, '1, b[1:0] ^ b[7:6], b[2] ^ b[9],
                      (o == 0) ? "R1/R2/R5" : (o == 1) ? "R1/R3/R5" : "R1/R4");
            end
        end

        // mask sweep: R6 R7 R8
        for (int k = 0; k < 4096; k++) begin
            logic [11:0] b;
            b = 12'(k);
            apply(b[1:0] ^ b[7:6], {b[3:0], b[11:10]}, ~{b[9:8], b[5:2]},
                  b[5:0], b[11:6], 2'b11, 1'b1, "R6/R7/R8");
        end

        // hold with in_valid low: R9 R12
        apply(2'b01, 6'b001100, 6'b110011, '0, '1, 2'b11, 1'b1, "R3");
        h1 = res_r1;
        h0 = res_r0;
        in_valid = 1'b0;
        opnd_r1 = '0;
        opnd_r0 = '1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", out_valid, 0);
            check(res_r1 == h1 && res_r0 == h0, "R9", {res_r1, res_r0}, {h1, h0});
            check(det == '0, "R12", det, 0);
        end
        finish_run();
    end

endmodule